// File: doc/BRIEF.md
# Configuration Register Write Unlock Sequencer

This block guards one configuration register that drives a clock-source switch. The upper byte of the register picks the clock source and the lowest byte carries the enable bits. The bus writes are narrow, so each byte of the register is written on its own, with an address and a per-byte strobe. No change reaches the register unless a two-step key exchange comes first. That exchange is two full-width writes of fixed key values to a dedicated key address, on back-to-back cycles.

A correct exchange opens a short window. The window admits exactly one single-byte write to the protected address and then closes by itself. The window also closes when a fixed number of cycles passes with no write to that address. Any attempt to write the protected address that is not accepted leaves the register untouched and sets a sticky violation flag. The flag stays set until reset. Changing both halves therefore takes two complete exchanges.

Top module: `cfg_unlock_gate`

## Requirements
- R1: After reset, `cfg_q` equals the reset value (default 16'h0001, i.e. source byte 8'h00 and enable byte 8'h01), `window_open` is 0 and `violation` is 0.
- R2: A write of 16'hABCD to the key address (default 4'h0, both strobes set) followed on the very next cycle by a write of 16'h4321 to that address sets `window_open` to 1 after the second write's clock edge.
- R3: One or more idle cycles between the first and the second key write leave `window_open` at 0.
- R4: Any write after the first key other than the second key closes the exchange. This includes a wrong key value or a write to another address. A following second key then leaves `window_open` at 0.
- R5: While the window is open, a write to the protected address (default 4'h1) with exactly one strobe bit set updates only that byte. Strobe bit 1 carries `wr_data[15:8]` into the source byte. Strobe bit 0 carries `wr_data[7:0]` into the enable byte. `clk_src_sel` mirrors `cfg_q[15:8]` and `clk_src_en` mirrors `cfg_q[7:0]`.
- R6: After one accepted protected write the window closes at once. A second protected write leaves `cfg_q` unchanged and sets `violation`.
- R7: The window accepts a protected write on each of the 4 clock edges after it opens (WIN_CYC = 4). If no protected write arrives by then, it closes. A later protected write is then ignored and flagged.
- R8: A protected-address write while locked leaves `cfg_q` unchanged and sets `violation`, which stays 1 until reset. A write to an unrelated address while locked sets no flag.
- R9: While open, a protected-address write whose strobe has no bit set, or more than one bit set, is rejected. The register is unchanged, `violation` is set and the window closes.
- R10: The two keys written in reverse order (16'h4321 then 16'hABCD) leave `window_open` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | ADDR_W (4) | Bus write address |
| wr_be | input | DATA_W/8 (2) | Per-byte write strobe |
| wr_data | input | DATA_W (16) | Bus write data |
| cfg_q | output | DATA_W (16) | Protected register contents |
| clk_src_sel | output | 8 | Source select byte (top byte of `cfg_q`) |
| clk_src_en | output | 8 | Enable byte (low byte of `cfg_q`) |
| window_open | output | 1 | High while one protected write may be accepted |
| violation | output | 1 | Sticky flag for any rejected protected write |

## Verification
A wrong sequencer state appears on `window_open` one clock edge after the key write that should have moved it. An early or late close shows the same way, as a window that opens or closes one edge off. A wrong acceptance decision shows in `cfg_q` and on `violation` on the edge that samples the protected write. A byte-lane mix-up shows as the wrong half of `cfg_q` changing. The window boundary is checked both ways: a write on the last allowed edge must land, and a write one edge later must be flagged.

// File: rtl/cfg_unlock_pkg.sv
package cfg_unlock_pkg;
   typedef enum logic [1:0] {
      ST_LOCKED = 2'd0,
      ST_ARMED  = 2'd1,
      ST_OPEN   = 2'd2
   } gate_st_e;
endpackage

// File: rtl/cfg_unlock_decode.sv
module cfg_unlock_decode #(
   parameter int          ADDR_W   = 4,
   parameter int          DATA_W   = 16,
   parameter logic [3:0]  KEY_ADDR = 4'h0,
   parameter logic [3:0]  REG_ADDR = 4'h1,
   parameter logic [15:0] KEY_A    = 16'hABCD,
   parameter logic [15:0] KEY_B    = 16'h4321,
   localparam int         LANES    = DATA_W / 8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic              key_a_hit,
   output logic              key_b_hit,
   output logic              reg_hit,
   output logic              lane_ok
);
   logic full_wr;
   logic at_key;

   assign full_wr   = &wr_be;
   assign at_key    = wr_en && (wr_addr == ADDR_W'(KEY_ADDR)) && full_wr;
   assign key_a_hit = at_key && (wr_data == DATA_W'(KEY_A));
   assign key_b_hit = at_key && (wr_data == DATA_W'(KEY_B));
   assign reg_hit   = wr_en && (wr_addr == ADDR_W'(REG_ADDR));
   assign lane_ok   = $onehot(wr_be);
endmodule

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
   import cfg_unlock_pkg::*;
#(
   parameter int WIN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_a_hit,
   input  logic key_b_hit,
   input  logic reg_hit,
   input  logic lane_ok,
   output logic accept,
   output logic window_open,
   output logic violation
);
   localparam int CNT_W = (WIN_CYC > 1) ? $clog2(WIN_CYC) : 1;

   gate_st_e st_q, st_d;
   logic     win_last;
   logic     reject;
   logic     viol_q;

   assign accept = (st_q == ST_OPEN) && reg_hit && lane_ok;
   assign reject = reg_hit && !accept;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_LOCKED: if (key_a_hit) st_d = ST_ARMED;
         ST_ARMED:  st_d = key_b_hit ? ST_OPEN : ST_LOCKED;
         ST_OPEN:   if (reg_hit || win_last) st_d = ST_LOCKED;
         default:   st_d = ST_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_LOCKED;
      else        st_q <= st_d;
   end

   generate
      if (WIN_CYC > 1) begin : g_win_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (st_q == ST_ARMED && key_b_hit)
               cnt_q <= CNT_W'(WIN_CYC - 1);
            else if (st_q == ST_OPEN && cnt_q != '0)
               cnt_q <= cnt_q - CNT_W'(1);
         end
         assign win_last = (cnt_q == '0);
      end else begin : g_win_single
         assign win_last = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      viol_q <= 1'b0;
      else if (reject) viol_q <= 1'b1;
   end

   assign window_open = (st_q == ST_OPEN);
   assign violation   = viol_q;
endmodule

// File: rtl/cfg_unlock_reg.sv
module cfg_unlock_reg #(
   parameter int          DATA_W  = 16,
   parameter logic [15:0] RST_VAL = 16'h0001,
   localparam int         LANES   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cfg_q
);
   localparam logic [DATA_W-1:0] RST_W = DATA_W'(RST_VAL);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cfg_q[l*8 +: 8] <= RST_W[l*8 +: 8];
            else if (accept && wr_be[l])
               cfg_q[l*8 +: 8] <= wr_data[l*8 +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/cfg_unlock_gate.sv
module cfg_unlock_gate #(
   parameter int          ADDR_W   = 4,
   parameter int          DATA_W   = 16,
   parameter logic [3:0]  KEY_ADDR = 4'h0,
   parameter logic [3:0]  REG_ADDR = 4'h1,
   parameter logic [15:0] KEY_A    = 16'hABCD,
   parameter logic [15:0] KEY_B    = 16'h4321,
   parameter logic [15:0] RST_VAL  = 16'h0001,
   parameter int          WIN_CYC  = 4,
   localparam int         LANES    = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANES-1:0]  wr_be,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] cfg_q,
   output logic [7:0]        clk_src_sel,
   output logic [7:0]        clk_src_en,
   output logic              window_open,
   output logic              violation
);
   generate
      if (DATA_W % 8 != 0 || DATA_W < 16 || DATA_W > 16)
         $error("cfg_unlock_gate: DATA_W must be 16 (two byte lanes)");
      if (ADDR_W < 1 || ADDR_W > 4)
         $error("cfg_unlock_gate: ADDR_W must be 1..4");
      if (WIN_CYC < 1)
         $error("cfg_unlock_gate: WIN_CYC must be at least 1");
      if (KEY_A == KEY_B)
         $error("cfg_unlock_gate: the two keys must differ");
      if (ADDR_W'(KEY_ADDR) == ADDR_W'(REG_ADDR))
         $error("cfg_unlock_gate: key and register addresses must differ");
   endgenerate

   logic key_a_hit, key_b_hit, reg_hit, lane_ok, accept;

   cfg_unlock_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
      .REG_ADDR(REG_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
   ) u_dec (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
      .key_a_hit(key_a_hit), .key_b_hit(key_b_hit),
      .reg_hit(reg_hit), .lane_ok(lane_ok)
   );

   cfg_unlock_fsm #(.WIN_CYC(WIN_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .key_a_hit(key_a_hit), .key_b_hit(key_b_hit),
      .reg_hit(reg_hit), .lane_ok(lane_ok),
      .accept(accept), .window_open(window_open), .violation(violation)
   );

   cfg_unlock_reg #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_reg (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .wr_be(wr_be), .wr_data(wr_data), .cfg_q(cfg_q)
   );

   assign clk_src_sel = cfg_q[DATA_W-1 -: 8];
   assign clk_src_en  = cfg_q[7:0];
endmodule

// File: rtl/cfg_unlock_chk.sv
module cfg_unlock_chk #(
   parameter int          ADDR_W   = 4,
   parameter int          DATA_W   = 16,
   parameter logic [3:0]  KEY_ADDR = 4'h0,
   parameter logic [3:0]  REG_ADDR = 4'h1,
   parameter logic [15:0] KEY_B    = 16'h4321,
   parameter logic [15:0] RST_VAL  = 16'h0001,
   localparam int         LANES    = DATA_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [LANES-1:0]  wr_be,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] cfg_q,
   input logic              window_open,
   input logic              violation
);
   logic [DATA_W-1:0] prev_q;
   logic              prev_open;
   logic              prev_vld;
   logic [LANES-1:0]  lane_chg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q    <= DATA_W'(RST_VAL);
         prev_open <= 1'b0;
         prev_vld  <= 1'b0;
      end else begin
         prev_q    <= cfg_q;
         prev_open <= window_open;
         prev_vld  <= 1'b1;
      end
   end

   for (genvar l = 0; l < LANES; l++) begin : g_chg
      assign lane_chg[l] = (prev_q[l*8 +: 8] != cfg_q[l*8 +: 8]);
   end

   // R8
   locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(REG_ADDR) && !window_open)
      |=> ($stable(cfg_q) && violation));

   // R8
   sticky_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      violation |=> violation);

   // R2
   open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(window_open) |-> $past(wr_en && wr_addr == ADDR_W'(KEY_ADDR)
                                   && (&wr_be) && wr_data == DATA_W'(KEY_B)));

   // R6
   single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (window_open && wr_en && wr_addr == ADDR_W'(REG_ADDR)) |=> !window_open);

   // R5
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prev_vld |-> $onehot0(lane_chg));

   // R6
   change_needs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prev_vld && (|lane_chg)) |-> prev_open);
endmodule

bind cfg_unlock_gate cfg_unlock_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
   .REG_ADDR(REG_ADDR), .KEY_B(KEY_B), .RST_VAL(RST_VAL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_be(wr_be), .wr_data(wr_data), .cfg_q(cfg_q),
   .window_open(window_open), .violation(violation)
);

// File: tb/sim_cfg_unlock_gate.sv
module sim_cfg_unlock_gate;
   localparam logic [3:0]  KADR = 4'h0;
   localparam logic [3:0]  RADR = 4'h1;
   localparam logic [3:0]  OADR = 4'h2;
   localparam logic [15:0] KA   = 16'hABCD;
   localparam logic [15:0] KB   = 16'h4321;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [1:0]  wr_be = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] cfg_q;
   logic [7:0]  clk_src_sel, clk_src_en;
   logic        window_open, violation;

   always #5 clk = ~clk;

   cfg_unlock_gate u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_be(wr_be), .wr_data(wr_data), .cfg_q(cfg_q),
      .clk_src_sel(clk_src_sel), .clk_src_en(clk_src_en),
      .window_open(window_open), .violation(violation)
   );

   typedef struct {
      string       tag;
      logic [15:0] cfg;
      logic        open;
      logic        viol;
   } exp_t;

   exp_t sb[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // monitor: compares outputs at the falling edge against queued items
   initial begin : mon
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            e = sb.pop_front();
            checks++;
            if (cfg_q !== e.cfg || window_open !== e.open || violation !== e.viol
                || clk_src_sel !== e.cfg[15:8] || clk_src_en !== e.cfg[7:0]) begin
               errors++;
               $display("FAIL %s: got cfg=%h sel=%h en=%h open=%b viol=%b, expected cfg=%h open=%b viol=%b",
                        e.tag, cfg_q, clk_src_sel, clk_src_en, window_open, violation,
                        e.cfg, e.open, e.viol);
            end
         end
      end
   end

   task automatic expect_st(input string tag, input logic [15:0] c,
                            input logic o, input logic v);
      exp_t e;
      e.tag = tag; e.cfg = c; e.open = o; e.viol = v;
      sb.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_be = be; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0; wr_addr = '0; wr_be = '0; wr_data = '0;
   endtask

   task automatic do_reset();
      idle(1);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic unlock();
      wr(KADR, 2'b11, KA);
      wr(KADR, 2'b11, KB);
   endtask

   initial begin
      #3;
      idle(2);
      rst_n = 1'b1;
      expect_st("R1 reset state", 16'h0001, 1'b0, 1'b0);

      // R2 / R5 / R6
      unlock();
      expect_st("R2 window opens", 16'h0001, 1'b1, 1'b0);
      wr(RADR, 2'b01, 16'h77F0);
      expect_st("R5 enable byte write", 16'h00F0, 1'b0, 1'b0);
      wr(RADR, 2'b10, 16'h0700);
      expect_st("R6 second write ignored", 16'h00F0, 1'b0, 1'b1);

      // R3 gap between keys, R8 locked write
      do_reset();
      expect_st("R1 reset after use", 16'h0001, 1'b0, 1'b0);
      wr(KADR, 2'b11, KA);
      idle(1);
      wr(KADR, 2'b11, KB);
      expect_st("R3 gap keeps locked", 16'h0001, 1'b0, 1'b0);
      wr(RADR, 2'b10, 16'h0500);
      expect_st("R8 locked write flagged", 16'h0001, 1'b0, 1'b1);
      idle(5);
      expect_st("R8 flag sticky", 16'h0001, 1'b0, 1'b1);

      // R4 / R10 / R8 unrelated address
      do_reset();
      wr(OADR, 2'b01, 16'h00AA);
      expect_st("R8 unrelated write no flag", 16'h0001, 1'b0, 1'b0);
      wr(KADR, 2'b11, KA);
      wr(KADR, 2'b11, 16'h1234);
      wr(KADR, 2'b11, KB);
      expect_st("R4 wrong second key", 16'h0001, 1'b0, 1'b0);
      wr(KADR, 2'b11, KB);
      wr(KADR, 2'b11, KA);
      expect_st("R10 reversed keys", 16'h0001, 1'b0, 1'b0);
      idle(1);
      wr(KADR, 2'b11, KA);
      wr(OADR, 2'b11, KB);
      wr(KADR, 2'b11, KB);
      expect_st("R4 foreign write between keys", 16'h0001, 1'b0, 1'b0);
      unlock();
      expect_st("R2 reopens after failures", 16'h0001, 1'b1, 1'b0);
      idle(5);

      // R7 window boundary
      do_reset();
      unlock();
      idle(3);
      expect_st("R7 still open on last edge", 16'h0001, 1'b1, 1'b0);
      wr(RADR, 2'b10, 16'h09FF);
      expect_st("R7 write on last edge lands", 16'h0901, 1'b0, 1'b0);
      unlock();
      idle(4);
      expect_st("R7 window expired", 16'h0901, 1'b0, 1'b0);
      wr(RADR, 2'b01, 16'h0033);
      expect_st("R7 late write flagged", 16'h0901, 1'b0, 1'b1);

      // R9 bad strobes
      do_reset();
      unlock();
      wr(RADR, 2'b11, 16'h1234);
      expect_st("R9 both lanes rejected", 16'h0001, 1'b0, 1'b1);
      do_reset();
      unlock();
      wr(RADR, 2'b00, 16'h1234);
      expect_st("R9 empty strobe rejected", 16'h0001, 1'b0, 1'b1);

      idle(3);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200_000 * 10);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got run still active, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule